// File: doc/BRIEF.md
# Tagged Translation Cache with Access Protection

This block is a small fully associative cache of page-table entries that turns a virtual address into a physical one. Each entry holds a virtual page number, a frame number, an address-space tag and a set of permission and status flags. A lookup compares every valid entry against the page-number bits of the request and the current address-space register at the same time. The block then returns either the translated address with the page's cacheable flag, or a fault code that tells software what went wrong. The block does not walk page tables. Every miss comes back as a fault, and software refills the cache through a fill port at an index it chooses.

Lookups use a valid/ready handshake on both sides. A request is accepted when `req_valid` and `req_ready` are both high. Its result shows up in the output register on the next cycle and stays there until the consumer takes it with `res_ready`. `req_ready` is low only while a result is held and `res_ready` is low, so the output stage provides back-pressure and cannot overflow. The address-space register, the fill port and the two invalidate commands are plain single-cycle control strobes.

Top module: `tagged_xlat_cache`

## Requirements
- R1: After reset, `res_valid` is 0, `req_ready` is 1 and no entry is valid, so the first lookup reports a miss.
- R2: `req_ready` equals `!res_valid || res_ready`. An accepted request raises `res_valid` in the following cycle. While `res_valid` is high and `res_ready` is low, every result output stays stable.
- R3: A lookup hits when a valid entry's page number equals `req_vaddr[31:12]` and that entry's tag equals the current address-space register. Permitted hits give `res_fault`=0, `res_hit`=1, `res_paddr` = {frame, `req_vaddr[11:0]`} and `res_cache` = the entry's cacheable flag. On any fault, `res_paddr` carries only the page offset (upper bits 0) and `res_cache` is 0.
- R4: `ctx_we` loads `ctx_id` into the address-space register at the clock edge. A fill stores the register's value as the entry tag, and a later lookup under a different register value does not hit that entry.
- R5: Access types are encoded in `req_type` as 0 read, 1 write and 2 execute (3 is treated as read). On a miss, reads and executes report fault code 1 and writes report fault code 2.
- R6: A write that hits an entry whose writable flag is clear reports fault code 3.
- R7: An execute that hits an entry whose execute flag is clear reports fault code 4.
- R8: `res_was_ref` and `res_was_dirty` report the hit entry's referenced and dirty flags as they were before the access. A permitted access sets referenced, and a permitted write also sets dirty. A faulted access changes neither flag. A fill clears both.
- R9: When several valid entries match, the one with the lowest index supplies the translation.
- R10: `inv_one` clears the valid flag of entry `inv_idx`, and `inv_all` clears the valid flag of every entry. Both take effect at the clock edge.
- R11: When several updates reach one entry in the same cycle, the order of precedence is `inv_all`, then fill, then `inv_one`, then the flag update from a lookup. A lookup always sees the entries as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_we | input | 1 | Load the address-space register |
| ctx_id | input | ASID_W | New address-space value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | VA_W | Virtual address |
| req_type | input | 2 | Access type: 0 read, 1 write, 2 execute |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_hit | output | 1 | Permitted translation |
| res_fault | output | 3 | 0 none, 1 read miss, 2 write miss, 3 read-only, 4 no-execute |
| res_paddr | output | PFN_W+PAGE_BITS | Physical address |
| res_cache | output | 1 | Page is cacheable |
| res_was_ref | output | 1 | Referenced flag before this access |
| res_was_dirty | output | 1 | Dirty flag before this access |
| fill_en | input | 1 | Write an entry |
| fill_idx | input | $clog2(ENTRIES) | Entry index for the fill |
| fill_vpn | input | VA_W-PAGE_BITS | Page number for the fill |
| fill_pfn | input | PFN_W | Frame number for the fill |
| fill_w | input | 1 | Writable flag for the fill |
| fill_x | input | 1 | Execute flag for the fill |
| fill_c | input | 1 | Cacheable flag for the fill |
| inv_one | input | 1 | Invalidate one entry |
| inv_idx | input | $clog2(ENTRIES) | Entry index to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The same page is looked up with each of the three access types against entries whose writable and execute flags differ. This separates the two protection faults from each other and from a plain hit. Each miss is produced twice, once with an unknown page number and once with a known page under a different address-space value, so the tag comparison is tested separately from the page comparison. Two entries that share a page number, followed by invalidation of the lower one, show whether index priority is applied. Fills that coincide with invalidates show the order of precedence. Repeated reads and writes to one page expose the referenced and dirty flags through the result. A request held under back-pressure confirms that results stay stable.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RD_MISS = 3'd1,
    FLT_WR_MISS = 3'd2,
    FLT_RO      = 3'd3,
    FLT_NX      = 3'd4
  } flt_e;

  typedef struct packed {
    logic v;
    logic x;
    logic w;
    logic c;
    logic d;
    logic r;
  } pte_flags_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_tag,
  input  logic [VPN_W-1:0]               look_vpn,
  input  logic [ASID_W-1:0]              look_tag,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_vpn[g] == look_vpn) && (ent_tag[g] == look_tag);
  end

  // lowest matching index wins: scan downward so the last write is the lowest
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |eq;
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  logic       hit,
  input  logic [1:0] acc,
  input  logic       ent_w,
  input  logic       ent_x,
  output flt_e       fault,
  output logic       grant,
  output logic       is_write
);
  always_comb begin
    is_write = (acc == ACC_WR);
    if (!hit)                          fault = is_write ? FLT_WR_MISS : FLT_RD_MISS;
    else if (is_write && !ent_w)       fault = FLT_RO;
    else if (acc == ACC_EX && !ent_x)  fault = FLT_NX;
    else                               fault = FLT_NONE;
    grant = (fault == FLT_NONE);
  end
endmodule

// File: rtl/tagged_xlat_cache.sv
module tagged_xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int ASID_W    = 8,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PA_W     = PFN_W + PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_we,
  input  logic [ASID_W-1:0] ctx_id,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_type,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [2:0]        res_fault,
  output logic [PA_W-1:0]   res_paddr,
  output logic              res_cache,
  output logic              res_was_ref,
  output logic              res_was_dirty,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_w,
  input  logic              fill_x,
  input  logic              fill_c,
  input  logic              inv_one,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic              inv_all
);
  logic [ASID_W-1:0]              ctx_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0]  e_pfn;
  logic [ENTRIES-1:0][ASID_W-1:0] e_tag;
  pte_flags_t [ENTRIES-1:0]       e_flg;
  logic [ENTRIES-1:0]             e_valid;

  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  flt_e             fault;
  logic             grant;
  logic             is_write;
  logic             accept;
  pte_flags_t       sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign e_valid[g] = e_flg[g].v;
  end

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .ent_valid (e_valid),
    .ent_vpn   (e_vpn),
    .ent_tag   (e_tag),
    .look_vpn  (req_vaddr[VA_W-1:PAGE_BITS]),
    .look_tag  (ctx_q),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx)
  );

  assign sel = e_flg[hit_idx];

  xlat_perm u_perm (
    .hit      (any_hit),
    .acc      (req_type),
    .ent_w    (sel.w),
    .ent_x    (sel.x),
    .fault    (fault),
    .grant    (grant),
    .is_write (is_write)
  );

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) ctx_q <= '0;
    else if (ctx_we) ctx_q <= ctx_id;
  end

  // entry storage; precedence: invalidate-all, fill, single invalidate, flag update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_flg <= '0;
      e_vpn <= '0;
      e_pfn <= '0;
      e_tag <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_all) begin
          e_flg[i].v <= 1'b0;
        end else if (fill_en && fill_idx == IDX_W'(i)) begin
          e_vpn[i] <= fill_vpn;
          e_pfn[i] <= fill_pfn;
          e_tag[i] <= ctx_q;
          e_flg[i] <= '{v: 1'b1, x: fill_x, w: fill_w, c: fill_c, d: 1'b0, r: 1'b0};
        end else if (inv_one && inv_idx == IDX_W'(i)) begin
          e_flg[i].v <= 1'b0;
        end else if (accept && grant && hit_idx == IDX_W'(i)) begin
          e_flg[i].r <= 1'b1;
          if (is_write) e_flg[i].d <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_fault     <= FLT_NONE;
      res_paddr     <= '0;
      res_cache     <= 1'b0;
      res_was_ref   <= 1'b0;
      res_was_dirty <= 1'b0;
    end else if (accept) begin
      res_valid     <= 1'b1;
      res_hit       <= grant;
      res_fault     <= fault;
      res_paddr     <= {(grant ? e_pfn[hit_idx] : PFN_W'(0)), req_vaddr[PAGE_BITS-1:0]};
      res_cache     <= grant && sel.c;
      res_was_ref   <= any_hit && sel.r;
      res_was_dirty <= any_hit && sel.d;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tagged_xlat_cache_chk.sv
module tagged_xlat_cache_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_type,
  input logic            inv_all,
  input logic            res_valid,
  input logic            res_ready,
  input logic [2:0]      res_fault,
  input logic [PA_W-1:0] res_paddr
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fault) && $stable(res_paddr))); // R2

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (res_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]))); // R3

  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault <= 3'd4)); // R5

  AST_WRITE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'd1) |=> (res_fault != 3'd1 && res_fault != 3'd4)); // R6

  AST_READ_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'd0) |=> (res_fault == 3'd0 || res_fault == 3'd1)); // R5

  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_all) && req_valid && req_ready) |=> (res_fault == 3'd1 || res_fault == 3'd2)); // R10
endmodule

bind tagged_xlat_cache tagged_xlat_cache_chk #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .req_type  (req_type),
  .inv_all   (inv_all),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_fault (res_fault),
  .res_paddr (res_paddr)
);

// File: tb/sim_tagged_xlat_cache.sv
module sim_tagged_xlat_cache;
  localparam int ENTRIES = 16;
  localparam int IDX_W   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_we = 1'b0;
  logic [7:0]  ctx_id = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_type = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [2:0]  res_fault;
  logic [31:0] res_paddr;
  logic        res_cache, res_was_ref, res_was_dirty;
  logic        fill_en = 1'b0;
  logic [IDX_W-1:0] fill_idx = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_w = 1'b0, fill_x = 1'b0, fill_c = 1'b0;
  logic        inv_one = 1'b0;
  logic [IDX_W-1:0] inv_idx = '0;
  logic        inv_all = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tagged_xlat_cache #(.ENTRIES(ENTRIES)) u0 (
    .clk, .rst_n, .ctx_we, .ctx_id, .req_valid, .req_ready, .req_vaddr, .req_type,
    .res_valid, .res_ready, .res_hit, .res_fault, .res_paddr, .res_cache,
    .res_was_ref, .res_was_dirty, .fill_en, .fill_idx, .fill_vpn, .fill_pfn,
    .fill_w, .fill_x, .fill_c, .inv_one, .inv_idx, .inv_all
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] t);
    @(negedge clk);
    req_vaddr = va; req_type = t; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_ctx(input logic [7:0] id);
    @(negedge clk);
    ctx_we = 1'b1; ctx_id = id;
    @(negedge clk);
    ctx_we = 1'b0;
  endtask

  task automatic drive_fill(input int idx, input logic [19:0] vpn, input logic [19:0] pfn,
                            input bit w, input bit x, input bit c);
    fill_en = 1'b1; fill_idx = IDX_W'(idx); fill_vpn = vpn; fill_pfn = pfn;
    fill_w = w; fill_x = x; fill_c = c;
  endtask

  task automatic fill(input int idx, input logic [19:0] vpn, input logic [19:0] pfn,
                      input bit w, input bit x, input bit c);
    @(negedge clk);
    drive_fill(idx, vpn, pfn, w, x, c);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic t_reset;
    chk(res_valid == 1'b0, "R1 res_valid", 32'(res_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    look(32'h0100_5a6f, 2'd0);
    chk(res_fault == 3'd1, "R1 empty miss", 32'(res_fault), 1);
  endtask

  task automatic t_hit_flags;
    set_ctx(8'd5);
    fill(3, 20'h01005, 20'h0000e, 1'b1, 1'b0, 1'b1);
    look(32'h0100_5a6f, 2'd0);
    chk(res_fault == 3'd0 && res_hit, "R3 hit fault", 32'(res_fault), 0);
    chk(res_paddr == 32'h0000_ea6f, "R3 paddr", res_paddr, 32'h0000_ea6f);
    chk(res_cache == 1'b1, "R3 cacheable", 32'(res_cache), 1);
    chk(res_was_ref == 1'b0, "R8 fresh ref", 32'(res_was_ref), 0);
    look(32'h0100_5a6f, 2'd0);
    chk(res_was_ref == 1'b1 && res_was_dirty == 1'b0, "R8 ref after read",
        {30'd0, res_was_ref, res_was_dirty}, 32'h2);
    look(32'h0100_5004, 2'd1);
    chk(res_fault == 3'd0, "R8 permitted write", 32'(res_fault), 0);
    look(32'h0100_5004, 2'd0);
    chk(res_was_dirty == 1'b1, "R8 dirty after write", 32'(res_was_dirty), 1);
  endtask

  task automatic t_tag;
    set_ctx(8'd6);
    look(32'h0100_5a6f, 2'd0);
    chk(res_fault == 3'd1, "R4 other tag read miss", 32'(res_fault), 1);
    look(32'h0100_5a6f, 2'd1);
    chk(res_fault == 3'd2, "R5 write miss", 32'(res_fault), 2);
    look(32'h0100_5a6f, 2'd2);
    chk(res_fault == 3'd1, "R5 exec miss", 32'(res_fault), 1);
    set_ctx(8'd5);
    look(32'h0100_5a6f, 2'd0);
    chk(res_fault == 3'd0, "R4 tag restored", 32'(res_fault), 0);
  endtask

  task automatic t_protect;
    look(32'h0100_5000, 2'd2);
    chk(res_fault == 3'd4, "R7 no-execute", 32'(res_fault), 4);
    chk(res_paddr == 32'h0 && res_cache == 1'b0, "R3 fault paddr", res_paddr, 0);
    fill(4, 20'h00400, 20'h12345, 1'b0, 1'b1, 1'b0);
    look(32'h0040_0123, 2'd1);
    chk(res_fault == 3'd3, "R6 read-only", 32'(res_fault), 3);
    look(32'h0040_0123, 2'd0);
    chk(res_was_ref == 1'b0 && res_was_dirty == 1'b0, "R8 fault left flags",
        {30'd0, res_was_ref, res_was_dirty}, 0);
    look(32'h0040_0abc, 2'd2);
    chk(res_fault == 3'd0 && res_paddr == 32'h1234_5abc && res_cache == 1'b0,
        "R7 exec allowed", res_paddr, 32'h1234_5abc);
  endtask

  task automatic t_priority;
    fill(9, 20'h00777, 20'h00099, 1'b1, 1'b1, 1'b0);
    fill(2, 20'h00777, 20'h00022, 1'b1, 1'b1, 1'b0);
    look(32'h0077_7010, 2'd0);
    chk(res_paddr == 32'h0002_2010, "R9 lowest index", res_paddr, 32'h0002_2010);
    @(negedge clk); inv_one = 1'b1; inv_idx = 4'd2;
    @(negedge clk); inv_one = 1'b0;
    look(32'h0077_7010, 2'd0);
    chk(res_paddr == 32'h0009_9010, "R10 single invalidate", res_paddr, 32'h0009_9010);
    @(negedge clk);
    drive_fill(9, 20'h00777, 20'h00055, 1'b1, 1'b1, 1'b0);
    inv_one = 1'b1; inv_idx = 4'd9;
    @(negedge clk); fill_en = 1'b0; inv_one = 1'b0;
    look(32'h0077_7010, 2'd0);
    chk(res_fault == 3'd0 && res_paddr == 32'h0005_5010, "R11 fill beats inv_one",
        res_paddr, 32'h0005_5010);
  endtask

  task automatic t_flush;
    @(negedge clk); inv_all = 1'b1;
    drive_fill(7, 20'h00888, 20'h00011, 1'b1, 1'b1, 1'b1);
    @(negedge clk); inv_all = 1'b0; fill_en = 1'b0;
    look(32'h0100_5a6f, 2'd0);
    chk(res_fault == 3'd1, "R10 invalidate all", 32'(res_fault), 1);
    look(32'h0088_8000, 2'd1);
    chk(res_fault == 3'd2, "R11 inv_all beats fill", 32'(res_fault), 2);
  endtask

  task automatic t_backpressure;
    fill(1, 20'h00abc, 20'h00ddd, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    res_ready = 1'b0;
    req_vaddr = 32'h00ab_c111; req_type = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    chk(res_valid && req_ready == 1'b0, "R2 stalled ready", 32'(req_ready), 0);
    req_vaddr = 32'h0099_9222;
    @(negedge clk);
    chk(res_paddr == 32'h00dd_d111, "R2 held result", res_paddr, 32'h00dd_d111);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid && res_fault == 3'd1 && res_paddr == 32'h0000_0222, "R2 next result",
        res_paddr, 32'h0000_0222);
    @(negedge clk);
    chk(res_valid == 1'b0, "R2 drained", 32'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit_flags();
    t_tag();
    t_protect();
    t_priority();
    t_flush();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule